// File: doc/BRIEF.md
# Ping-Pong Pixel Frame Streamer

This block keeps two frame stores of 32-bit words and plays one of them out as a stream of 24-bit pixels while a producer refills the other. The stored bytes form one continuous green-red-blue byte stream, four bytes to a word. A pixel can therefore start in one word and finish in the next: every three words give four pixels. The consumer paces the output through a valid/ready handshake. The last pixel of each frame carries an end-of-frame marker.

When a frame ends, the block moves straight on to the other store if the producer has marked it ready. If the other store is not ready, the block raises a sticky underflow flag and stops. It stays stopped until a store is marked ready. Writes aimed at the store being played are dropped and counted.

A controller with three states sequences the block. ST_IDLE is the state after reset, before any frame has been played. ST_PLAY presents pixels. ST_HALT is the state after an underflow. The transitions are:
- start: ST_IDLE to ST_PLAY, when any store is marked ready.
- swap: ST_PLAY to ST_PLAY, on the last handshake of a frame while the other store is marked ready.
- starve: ST_PLAY to ST_HALT, on the last handshake of a frame while the other store is not marked ready.
- resume: ST_HALT to ST_PLAY, when any store is marked ready.

Top module: `frame_streamer`

## Requirements
- R1: Byte k of the frame stream sits in word k/4. Within that word, lane 0 is bits 31:24 and lane 3 is bits 7:0. Pixel p is made of bytes 3p, 3p+1 and 3p+2. These go out as pix_data[23:16] = green, [15:8] = red and [7:0] = blue.
- R2: A pixel is consumed only on a cycle where pix_valid and pix_ready are both high. While pix_ready is low, pix_valid and pix_data hold their values.
- R3: pix_last is high exactly on pixel led_count-1 of each frame.
- R4: On the last handshake of a frame, if the other store is marked ready, play_sel flips and that store's pixel 0 is presented on the next cycle. The underflow flag stays clear.
- R5: On the last handshake of a frame, if the other store is not marked ready, underflow goes high and stays high until reset. pix_valid then stays low until a store is marked ready.
- R6: While a frame is playing, a write whose store select (wr_sel) equals play_sel does not change that store, and rej_cnt increments by one. Writes to the other store take effect.
- R7: led_count may be anything from 1 to MAX_PIX. The bytes of the final word that lie past byte 3*led_count-1 are discarded.
- R8: After reset, pix_valid, underflow and rej_cnt are 0. The first store marked ready starts playing; if both are ready, store 0 goes first.
- R9: A ready mark is used up when its store starts playing. A mark on the store that is currently playing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Producer word write strobe |
| wr_sel | input | 1 | Store selected for the write |
| wr_addr | input | AW | Word index within the store |
| wr_data | input | 32 | Packed word, first byte in bits 31:24 |
| mark_en | input | 1 | Marks a store as holding a complete frame |
| mark_sel | input | 1 | Store being marked |
| led_count | input | CW | Pixels per frame, 1..MAX_PIX |
| pix_ready | input | 1 | Consumer can accept a pixel |
| pix_valid | output | 1 | A pixel is presented |
| pix_data | output | 24 | Pixel, green in bits 23:16, red in 15:8, blue in 7:0 |
| pix_last | output | 1 | Presented pixel is the last of its frame |
| play_sel | output | 1 | Store being played |
| underflow | output | 1 | Sticky: a frame ended with no ready successor |
| rej_cnt | output | RCW | Count of writes dropped because they hit the playing store |

## Verification
A wrong byte pointer shows up as a wrong pixel on the very next handshake. When the pointer crosses a word boundary, the error appears as a straddling pixel that mixes bytes from the wrong words. A lost or stuck ready mark shows up at the end of the current frame: either the underflow flag rises a cycle too early, or a stale frame is replayed. The scoreboard catches both within one pixel. A broken store lock corrupts a pixel that is still to be played in the current frame, and it leaves rej_cnt wrong one cycle after the write.

// File: rtl/fs_pkg.sv
package fs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAY = 2'd1,
        ST_HALT = 2'd2
    } fs_state_e;

    // words needed to hold a frame of p pixels at three bytes each
    function automatic int words_for(input int p);
        return (3 * p + 3) / 4;
    endfunction
endpackage

// File: rtl/fs_bank.sv
module fs_bank #(
    parameter int DEPTH = 15,
    parameter int AW    = 4,
    parameter int RCW   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic [AW-1:0]  wr_addr,
    input  logic [31:0]    wr_data,
    input  logic           lock_on,
    input  logic           lock_sel,
    input  logic           rd_sel,
    input  logic [AW-1:0]  rd_addr,
    output logic [31:0]    rd_lo,
    output logic [31:0]    rd_hi,
    output logic [RCW-1:0] rej_cnt
);
    logic        blocked;
    logic [AW:0] nxt_addr;
    logic [31:0] lo_w [2];
    logic [31:0] hi_w [2];

    assign blocked  = wr_en && lock_on && (wr_sel == lock_sel);
    assign nxt_addr = {1'b0, rd_addr} + 1'b1;

    for (genvar b = 0; b < 2; b++) begin : g_store
        logic [31:0] words [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && !blocked && (wr_sel == 1'(b)) && (32'(wr_addr) < DEPTH))
                words[wr_addr] <= wr_data;
        end
        assign lo_w[b] = words[rd_addr];
        assign hi_w[b] = (32'(nxt_addr) < DEPTH) ? words[nxt_addr[AW-1:0]] : 32'd0;
    end

    assign rd_lo = lo_w[rd_sel];
    assign rd_hi = hi_w[rd_sel];

    always_ff @(posedge clk) begin
        if (!rst_n)       rej_cnt <= '0;
        else if (blocked) rej_cnt <= rej_cnt + 1'b1;
    end
endmodule

// File: rtl/fs_unpack.sv
module fs_unpack (
    input  logic [1:0]  lane,
    input  logic [31:0] lo,
    input  logic [31:0] hi,
    output logic [23:0] pix
);
    logic [63:0] joined;
    logic [63:0] shifted;

    always_comb begin
        joined  = {lo, hi};
        shifted = joined << {lane, 3'b000};
        pix     = shifted[63:40];
    end
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
    import fs_pkg::*;
#(
    parameter int CW = 5,
    parameter int BW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mark_en,
    input  logic          mark_sel,
    input  logic [CW-1:0] led_count,
    input  logic          pix_ready,
    output logic          pix_valid,
    output logic          pix_last,
    output logic          cur_sel,
    output logic          lock_on,
    output logic          underflow,
    output logic [BW-1:0] bptr
);
    fs_state_e     state, nstate;
    logic [1:0]    rdy, rdy_n;
    logic [CW-1:0] idx;
    logic          take, at_end, start, swap, starve, new_sel;

    always_comb begin
        take    = (state == ST_PLAY) && pix_ready;
        at_end  = (idx == CW'(led_count - 1'b1));
        start   = (state != ST_PLAY) && (|rdy);
        swap    = take && at_end && rdy[~cur_sel];
        starve  = take && at_end && !rdy[~cur_sel];
        new_sel = start ? (rdy[~cur_sel] ? ~cur_sel : cur_sel) : ~cur_sel;

        nstate = state;
        unique case (state)
            ST_IDLE: if (|rdy)  nstate = ST_PLAY;
            ST_PLAY: if (starve) nstate = ST_HALT;
            ST_HALT: if (|rdy)  nstate = ST_PLAY;
            default: nstate = ST_IDLE;
        endcase

        rdy_n = rdy;
        if (mark_en && !((state == ST_PLAY) && (mark_sel == cur_sel)))
            rdy_n[mark_sel] = 1'b1;
        if (start || swap)
            rdy_n[new_sel] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy       <= '0;
            cur_sel   <= 1'b1;
            idx       <= '0;
            bptr      <= '0;
            underflow <= 1'b0;
        end else begin
            rdy <= rdy_n;
            if (start || swap) begin
                cur_sel <= new_sel;
                idx     <= '0;
                bptr    <= '0;
            end else if (take) begin
                idx  <= idx + 1'b1;
                bptr <= bptr + BW'(3);
            end
            if (starve) underflow <= 1'b1;
        end
    end

    assign pix_valid = (state == ST_PLAY);
    assign pix_last  = (state == ST_PLAY) && at_end;
    assign lock_on   = (state == ST_PLAY);
endmodule

// File: rtl/frame_streamer.sv
module frame_streamer
    import fs_pkg::*;
#(
    parameter int MAX_PIX = 20,
    parameter int RCW     = 8,
    localparam int DEPTH  = (3 * MAX_PIX + 3) / 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(MAX_PIX + 1),
    localparam int BW     = $clog2(4 * DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic [AW-1:0]  wr_addr,
    input  logic [31:0]    wr_data,
    input  logic           mark_en,
    input  logic           mark_sel,
    input  logic [CW-1:0]  led_count,
    input  logic           pix_ready,
    output logic           pix_valid,
    output logic [23:0]    pix_data,
    output logic           pix_last,
    output logic           play_sel,
    output logic           underflow,
    output logic [RCW-1:0] rej_cnt
);
    logic          lock_on;
    logic [BW-1:0] bptr;
    logic [31:0]   rd_lo, rd_hi;

    fs_ctrl #(.CW(CW), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mark_en(mark_en), .mark_sel(mark_sel),
        .led_count(led_count), .pix_ready(pix_ready), .pix_valid(pix_valid),
        .pix_last(pix_last), .cur_sel(play_sel), .lock_on(lock_on),
        .underflow(underflow), .bptr(bptr)
    );

    fs_bank #(.DEPTH(DEPTH), .AW(AW), .RCW(RCW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .lock_on(lock_on),
        .lock_sel(play_sel), .rd_sel(play_sel), .rd_addr(AW'(bptr >> 2)),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rej_cnt(rej_cnt)
    );

    fs_unpack u_unpack (
        .lane(bptr[1:0]), .lo(rd_lo), .hi(rd_hi), .pix(pix_data)
    );
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int RCW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           pix_valid,
    input logic           pix_ready,
    input logic [23:0]    pix_data,
    input logic           pix_last,
    input logic           play_sel,
    input logic           underflow,
    input logic [RCW-1:0] rej_cnt
);
    // R2
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_last)));
    // R5
    stop_on_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> !pix_valid);
    // R5
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(underflow));
    // R4
    store_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !(pix_ready && pix_last)) |=> $stable(play_sel));
    // R6
    reject_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_cnt != $past(rej_cnt)) |-> $past(wr_en));
endmodule

bind frame_streamer fs_checker #(.RCW(RCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_last(pix_last),
    .play_sel(play_sel), .underflow(underflow), .rej_cnt(rej_cnt)
);

// File: tb/sim_frame_streamer.sv
module sim_frame_streamer;
    localparam int MAX_PIX = 20;
    localparam int RCW     = 8;
    localparam int DEPTH   = (3 * MAX_PIX + 3) / 4;
    localparam int AW      = $clog2(DEPTH);
    localparam int CW      = $clog2(MAX_PIX + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0, wr_sel = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic           mark_en = 1'b0, mark_sel = 1'b0;
    logic [CW-1:0]  led_count = CW'(5);
    logic           pix_ready = 1'b0;
    logic           pix_valid, pix_last, play_sel, underflow;
    logic [23:0]    pix_data;
    logic [RCW-1:0] rej_cnt;

    int checks = 0, errors = 0, cyc = 0;
    bit hold = 1'b0;
    logic [24:0] expq [$];

    always #2 clk = ~clk;

    frame_streamer #(.MAX_PIX(MAX_PIX), .RCW(RCW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .mark_en(mark_en),
        .mark_sel(mark_sel), .led_count(led_count), .pix_ready(pix_ready),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_last(pix_last),
        .play_sel(play_sel), .underflow(underflow), .rej_cnt(rej_cnt)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one producer write, started and ended at a falling edge
    task automatic put(input bit sel, input int addr, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mark(input bit sel);
        mark_en = 1'b1; mark_sel = sel;
        @(negedge clk);
        mark_en = 1'b0;
    endtask

    // packs n pixels as a byte stream (R1) and queues the expected pixels
    task automatic load_frame(input bit sel, input int n, input int seed);
        logic [7:0]  bytes [64];
        logic [23:0] px;
        for (int k = 0; k < 64; k++) bytes[k] = 8'hA5;
        for (int i = 0; i < n; i++) begin
            px = 24'((seed * 40503) ^ (i * 7919) ^ (i << 13));
            bytes[3*i]   = px[23:16];
            bytes[3*i+1] = px[15:8];
            bytes[3*i+2] = px[7:0];
            expq.push_back({(i == n - 1), px});
        end
        for (int w = 0; w < (3 * n + 3) / 4; w++)
            put(sel, w, {bytes[4*w], bytes[4*w+1], bytes[4*w+2], bytes[4*w+3]});
    endtask

    // monitor: decides ready, then scores the pixel taken at the next rising edge
    bit          prev_stall = 1'b0;
    logic [24:0] prev_item;
    always @(negedge clk) begin
        bit r;
        logic [24:0] e;
        cyc++;
        if (rst_n && prev_stall) // R2
            check(pix_valid && ({pix_last, pix_data} == prev_item), "R2 hold",
                  {pix_valid, pix_last, pix_data}, {1'b1, prev_item});
        r = !hold && ((cyc % 5) != 2);
        pix_ready = r;
        prev_stall = rst_n && pix_valid && !r;
        prev_item  = {pix_last, pix_data};
        if (rst_n && pix_valid && r) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5 unexpected pixel", {pix_last, pix_data}, 0);
            end else begin
                e = expq.pop_front();
                check(pix_data == e[23:0], "R1 pixel", pix_data, e[23:0]);
                check(pix_last == e[24], "R3 last", pix_last, e[24]);
            end
        end
        if (cyc > 20000) begin
            check(1'b0, "watchdog", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: quiet after reset
        repeat (4) begin
            @(negedge clk);
            check(!pix_valid && !underflow && rej_cnt == 0, "R8 reset",
                  {pix_valid, underflow, rej_cnt}, 0);
        end

        // frame A in store 0, consumer held back
        hold = 1'b1;
        led_count = CW'(5);
        load_frame(1'b0, 5, 11);
        mark(1'b0);
        while (!(pix_valid && play_sel == 1'b0)) @(negedge clk);
        check(play_sel == 1'b0, "R8 first store", play_sel, 0);
        // R6: overwrite of pixel 4 in the playing store must be dropped
        put(1'b0, 3, 32'h0);
        check(rej_cnt == 1, "R6 reject count", rej_cnt, 1);
        load_frame(1'b1, 5, 23);
        mark(1'b1);
        hold = 1'b0;

        // R4: swap into store 1 without underflow
        while (expq.size() > 5) @(negedge clk);
        @(negedge clk);
        check(play_sel == 1'b1 && !underflow, "R4 swap", {play_sel, underflow}, 2);

        // R5 R9: the mark on store 1 was used up, so the frame end starves
        while (expq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        repeat (10) begin
            check(underflow && !pix_valid, "R5 R9 starve", {underflow, pix_valid}, 2);
            @(negedge clk);
        end

        // R7: minimum frame of one pixel, resumes from halt
        led_count = CW'(1);
        load_frame(1'b0, 1, 37);
        mark(1'b0);
        while (expq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(underflow && !pix_valid, "R5 sticky", {underflow, pix_valid}, 2);

        // R7: largest frame, partial last word
        led_count = CW'(MAX_PIX);
        load_frame(1'b1, MAX_PIX, 53);
        mark(1'b1);
        while (expq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(expq.size() == 0 && !pix_valid, "R7 frames drained", expq.size(), 0);
        check(rej_cnt == 1, "R6 final count", rej_cnt, 1);
        finish_run();
    end
endmodule